// File: doc/BRIEF.md
# Threshold and Duration Motion Interrupt Generator

This block watches a stream of signed three-axis acceleration samples and decides, one sample at a time, whether a motion event is in progress. For each axis it takes the magnitude of the sample and compares it with a programmable level. The level is the 7-bit threshold code multiplied by a fixed number of sample LSBs per code step. Each axis yields a high event (magnitude above the level) and a low event (magnitude at or below it). Software enables any subset of the six events and picks how they combine: in OR mode any enabled event qualifies; in AND mode every enabled event must hold together. AND of all three low events detects free fall.

A qualifying condition must persist over a programmed number of consecutive samples before it counts. The result drives an interrupt pin of selectable polarity and an 8-bit source status byte. When latching is on, a recognised event stays asserted until the host reads the status byte, and that read clears it. The host signals a read by strobing a read input for one cycle.

Top module: `motion_irq_gen`

## Requirements
- R1: After reset the source byte is 0x00 and the interrupt pin is at its inactive level.
- R2: Source byte layout: bit 7 reads 0, bit 6 is the active flag, and bits 5..0 are Z-high, Z-low, Y-high, Y-low, X-high, X-low. An axis high event is magnitude > threshold*2^STEP_SHIFT, and its low event is the complement of that. A flag reads 1 only when its event is true and its enable is set. In the enable inputs, bit 0 is X, bit 1 is Y and bit 2 is Z.
- R3: Magnitude is the absolute value of the two's complement sample, including the most negative code.
- R4: In OR mode (and_mode_i = 0) the condition is true when any enabled event is true.
- R5: In AND mode the condition is true when every enabled event is true, and it is never true with no event enabled.
- R6: The event is recognised on the (dur+1)-th consecutive valid sample with a true condition. A valid sample with a false condition restarts the count. Cycles without a valid sample neither advance nor reset the count.
- R7: With latching off, the active flag and the event flags follow each valid sample, so the active flag drops on the first sample whose condition is false. A read strobe has no effect in this mode.
- R8: With latching on, the active flag stays set once recognised and the event flags freeze until a read. A read without a sample clears the whole byte on the next cycle. While the active flag is clear, the event flags track each valid sample.
- R9: With latching on, a read in the same cycle as a valid sample takes that sample's result: a recognised event re-latches with fresh flags, otherwise the byte takes the new flags with the active flag clear.
- R10: irq_o equals the active flag when irq_act_low_i = 0 and its inverse when irq_act_low_i = 1.
- R11: The outputs change only on a clock edge with a valid sample or with a latched-mode read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | A new sample is present this cycle |
| smp_x_i | input | SAMPLE_W | X sample, two's complement |
| smp_y_i | input | SAMPLE_W | Y sample, two's complement |
| smp_z_i | input | SAMPLE_W | Z sample, two's complement |
| hi_en_i | input | 3 | High event enables (bit 0 X, 1 Y, 2 Z) |
| lo_en_i | input | 3 | Low event enables (bit 0 X, 1 Y, 2 Z) |
| and_mode_i | input | 1 | 1: AND of enabled events, 0: OR |
| ths_i | input | THS_W | Threshold code |
| dur_i | input | DUR_W | Extra consecutive samples required |
| latch_en_i | input | 1 | Hold the event until a status read |
| irq_act_low_i | input | 1 | Interrupt pin polarity select |
| src_rd_i | input | 1 | Status byte read strobe |
| irq_o | output | 1 | Interrupt pin |
| src_o | output | 8 | Source status byte |

## Verification
The bench builds the block with SAMPLE_W = 12 and STEP_SHIFT = 3. With these values the largest threshold code reaches a level of 1016, about half of full scale. The most negative sample, -2048, then falls within the directed cases, so the magnitude edge is exercised against a level it can cross. A 7-bit duration lets windows of a few samples be run with idle cycles between samples. In a long run of random cycles, every configuration field changes together with the samples and the read strobe. This covers latched reads that coincide with samples and switches between AND and OR modes.

// File: rtl/motion_irq_pkg.sv
package motion_irq_pkg;
  localparam int unsigned NUM_AXES = 3;
  localparam int unsigned NUM_EVT  = 2 * NUM_AXES;
  localparam int unsigned SRC_W    = 8;
  localparam int unsigned ACT_BIT  = 6;

  typedef enum logic {
    COMB_OR  = 1'b0,
    COMB_AND = 1'b1
  } comb_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } axis_evt_t;
endpackage

// File: rtl/axis_mag_cmp.sv
module axis_mag_cmp #(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned THS_W      = 7,
  parameter int unsigned STEP_SHIFT = 4
) (
  input  logic [SAMPLE_W-1:0]  smp_i,
  input  logic [THS_W-1:0]     ths_i,
  output motion_irq_pkg::axis_evt_t evt_o
);
  localparam int unsigned MAG_W = SAMPLE_W + 1;
  localparam int unsigned LVL_W = THS_W + STEP_SHIFT;
  localparam int unsigned CMP_W = (MAG_W > LVL_W) ? MAG_W : LVL_W;

  logic [MAG_W-1:0] ext;
  logic [MAG_W-1:0] mag;
  logic [CMP_W-1:0] mag_c;
  logic [CMP_W-1:0] lvl_c;

  always_comb begin
    ext   = {smp_i[SAMPLE_W-1], smp_i};
    // negation in SAMPLE_W+1 bits so the most negative code stays exact
    mag   = smp_i[SAMPLE_W-1] ? (~ext + MAG_W'(1)) : ext;
    mag_c = CMP_W'(mag);
    lvl_c = CMP_W'({ths_i, {STEP_SHIFT{1'b0}}});
    evt_o.hi = (mag_c > lvl_c);
    evt_o.lo = ~evt_o.hi;
  end
endmodule

// File: rtl/event_combine.sv
module event_combine
  import motion_irq_pkg::*;
(
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  comb_mode_e         mode_i,
  output logic [NUM_EVT-1:0] flags_o,
  output logic               cond_o
);
  always_comb begin
    flags_o = evt_i & en_i;
    unique case (mode_i)
      COMB_AND: cond_o = (en_i != '0) && (flags_o == en_i);
      default:  cond_o = (flags_o != '0);
    endcase
  end
endmodule

// File: rtl/dwell_counter.sv
module dwell_counter #(
  parameter int unsigned DUR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             cond_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             met_o
);
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (!cond_i)            cnt_q <= '0;
      else if (cnt_q < dur_i) cnt_q <= cnt_q + DUR_W'(1);
    end
  end

  assign met_o = valid_i & cond_i & (cnt_q >= dur_i);
endmodule

// File: rtl/src_latch.sv
module src_latch
  import motion_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               met_i,
  input  logic [NUM_EVT-1:0] flags_i,
  input  logic               latch_en_i,
  input  logic               rd_i,
  output logic               active_o,
  output logic [NUM_EVT-1:0] flags_o
);
  logic               act_q;
  logic [NUM_EVT-1:0] flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      flg_q <= '0;
    end else if (latch_en_i) begin
      if (valid_i) begin
        act_q <= met_i | (act_q & ~rd_i);
        if (!act_q || rd_i) flg_q <= flags_i;
      end else if (rd_i) begin
        act_q <= 1'b0;
        flg_q <= '0;
      end
    end else if (valid_i) begin
      act_q <= met_i;
      flg_q <= flags_i;
    end
  end

  assign active_o = act_q;
  assign flags_o  = flg_q;
endmodule

// File: rtl/motion_irq_gen.sv
module motion_irq_gen
  import motion_irq_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned THS_W      = 7,
  parameter int unsigned DUR_W      = 7,
  parameter int unsigned STEP_SHIFT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_x_i,
  input  logic [SAMPLE_W-1:0] smp_y_i,
  input  logic [SAMPLE_W-1:0] smp_z_i,
  input  logic [2:0]          hi_en_i,
  input  logic [2:0]          lo_en_i,
  input  logic                and_mode_i,
  input  logic [THS_W-1:0]    ths_i,
  input  logic [DUR_W-1:0]    dur_i,
  input  logic                latch_en_i,
  input  logic                irq_act_low_i,
  input  logic                src_rd_i,
  output logic                irq_o,
  output logic [7:0]          src_o
);
  logic [NUM_AXES-1:0][SAMPLE_W-1:0] smp;
  axis_evt_t [NUM_AXES-1:0]          axis_evt;
  logic [NUM_EVT-1:0]                evt_vec;
  logic [NUM_EVT-1:0]                en_vec;
  logic [NUM_EVT-1:0]                flags;
  logic [NUM_EVT-1:0]                flags_q;
  logic                              cond;
  logic                              met;
  logic                              active;

  assign smp = {smp_z_i, smp_y_i, smp_x_i};

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    axis_mag_cmp #(
      .SAMPLE_W  (SAMPLE_W),
      .THS_W     (THS_W),
      .STEP_SHIFT(STEP_SHIFT)
    ) u_cmp (
      .smp_i(smp[a]),
      .ths_i(ths_i),
      .evt_o(axis_evt[a])
    );
    assign evt_vec[2*a+1] = axis_evt[a].hi;
    assign evt_vec[2*a]   = axis_evt[a].lo;
    assign en_vec[2*a+1]  = hi_en_i[a];
    assign en_vec[2*a]    = lo_en_i[a];
  end

  event_combine u_comb (
    .evt_i  (evt_vec),
    .en_i   (en_vec),
    .mode_i (comb_mode_e'(and_mode_i)),
    .flags_o(flags),
    .cond_o (cond)
  );

  dwell_counter #(.DUR_W(DUR_W)) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(smp_valid_i),
    .cond_i (cond),
    .dur_i  (dur_i),
    .met_o  (met)
  );

  src_latch u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (smp_valid_i),
    .met_i     (met),
    .flags_i   (flags),
    .latch_en_i(latch_en_i),
    .rd_i      (src_rd_i),
    .active_o  (active),
    .flags_o   (flags_q)
  );

  assign src_o = {1'b0, active, flags_q};
  assign irq_o = active ^ irq_act_low_i;
endmodule

// File: rtl/motion_irq_gen_chk.sv
module motion_irq_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       smp_valid_i,
  input logic [2:0] hi_en_i,
  input logic [2:0] lo_en_i,
  input logic       and_mode_i,
  input logic       latch_en_i,
  input logic       irq_act_low_i,
  input logic       src_rd_i,
  input logic       irq_o,
  input logic [7:0] src_o
);
  // R10
  pin_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (src_o[6] ^ irq_act_low_i));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !(src_rd_i && latch_en_i)) |=> $stable(src_o));

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && src_rd_i && !smp_valid_i) |=> (src_o == 8'h00));

  // R8
  latch_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && src_o[6] && !src_rd_i) |=> src_o[6]);

  // R5
  and_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && and_mode_i && (hi_en_i == 3'b000) && (lo_en_i == 3'b000)
     && !latch_en_i) |=> !src_o[6]);
endmodule

bind motion_irq_gen motion_irq_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_valid_i  (smp_valid_i),
  .hi_en_i      (hi_en_i),
  .lo_en_i      (lo_en_i),
  .and_mode_i   (and_mode_i),
  .latch_en_i   (latch_en_i),
  .irq_act_low_i(irq_act_low_i),
  .src_rd_i     (src_rd_i),
  .irq_o        (irq_o),
  .src_o        (src_o)
);

// File: tb/motion_irq_gen_bench.sv
`timescale 1ns/1ps
module motion_irq_gen_bench;
  localparam int SW = 12;
  localparam int TW = 7;
  localparam int DW = 7;
  localparam int SS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [SW-1:0] sx = '0, sy = '0, sz = '0;
  logic [2:0]    hi_en = '0, lo_en = '0;
  logic          and_mode = 1'b0;
  logic [TW-1:0] ths = '0;
  logic [DW-1:0] dur = '0;
  logic          latch_en = 1'b0;
  logic          act_low = 1'b0;
  logic          rd = 1'b0;
  logic          irq;
  logic [7:0]    src;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  int m_cnt = 0;
  bit m_act = 0;
  int m_flg = 0;
  int lcg = 12345;

  always #4 clk = ~clk;

  motion_irq_gen #(.SAMPLE_W(SW), .THS_W(TW), .DUR_W(DW), .STEP_SHIFT(SS)) u_motion_irq_gen (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid),
    .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz),
    .hi_en_i(hi_en), .lo_en_i(lo_en), .and_mode_i(and_mode),
    .ths_i(ths), .dur_i(dur), .latch_en_i(latch_en),
    .irq_act_low_i(act_low), .src_rd_i(rd),
    .irq_o(irq), .src_o(src)
  );

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, exp);
    end
  endtask

  function automatic int mag(logic [SW-1:0] s);
    int v = int'($signed(s));
    return (v < 0) ? -v : v;
  endfunction

  // behavioural reference, run after each rising edge
  task automatic model_edge();
    int lvl = int'(ths) * (1 << SS);
    int ev = 0, en = 0, fl;
    bit cond, met;
    int m[3];
    m[0] = mag(sx); m[1] = mag(sy); m[2] = mag(sz);
    for (int a = 0; a < 3; a++) begin
      if (m[a] > lvl) ev |= (1 << (2*a+1)); else ev |= (1 << (2*a));
      if (hi_en[a]) en |= (1 << (2*a+1));
      if (lo_en[a]) en |= (1 << (2*a));
    end
    fl = ev & en;
    cond = and_mode ? (en != 0 && fl == en) : (fl != 0);
    if (valid) begin
      met = cond && (m_cnt >= int'(dur));
      if (!cond) m_cnt = 0; else if (m_cnt < int'(dur)) m_cnt++;
      if (latch_en) begin
        if (!m_act || rd) m_flg = fl;
        m_act = met || (m_act && !rd);
      end else begin
        m_act = met;
        m_flg = fl;
      end
    end else if (latch_en && rd) begin
      m_act = 0;
      m_flg = 0;
    end
  endtask

  task automatic cyc(bit v, int x, int y, int z, bit r);
    @(negedge clk);
    valid = v; sx = SW'(x); sy = SW'(y); sz = SW'(z); rd = r;
    @(posedge clk);
    model_edge();
    #1;
    chk({tag, " src"}, int'(src), (m_act ? 8'h40 : 0) | m_flg);
    chk({tag, " irq"}, int'(irq), int'(m_act ^ act_low));
  endtask

  task automatic cfg(bit [2:0] he, bit [2:0] le, bit am, int t, int d, bit la, bit al);
    @(negedge clk);
    hi_en = he; lo_en = le; and_mode = am; ths = TW'(t); dur = DW'(d);
    latch_en = la; act_low = al; valid = 0; rd = 0;
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'h7fffff;
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk("R1 reset src", int'(src), 0);
    chk("R1 reset irq", int'(irq), 0);
    @(negedge clk) rst_n = 1'b1;

    // R2: level = 10*8 = 80
    tag = "R2";
    cfg(3'b001, 3'b000, 0, 10, 0, 0, 0);
    cyc(1, 81, 0, 0, 0);  chk("R2 x above", int'(src), 8'h42);
    cyc(1, 80, 0, 0, 0);  chk("R2 x at level", int'(src), 8'h00);
    cfg(3'b000, 3'b001, 0, 10, 0, 0, 0);
    cyc(1, 80, 999, 0, 0); chk("R2 x low", int'(src), 8'h41);

    // R3
    tag = "R3";
    cfg(3'b001, 3'b000, 0, 10, 0, 0, 0);
    cyc(1, -81, 0, 0, 0); chk("R3 negative", int'(src), 8'h42);
    cfg(3'b001, 3'b000, 0, 127, 0, 0, 0);
    cyc(1, -2048, 0, 0, 0); chk("R3 most negative", int'(src), 8'h42);
    cyc(1, -1016, 0, 0, 0); chk("R3 at max level", int'(src), 8'h00);

    // R4
    tag = "R4";
    cfg(3'b111, 3'b000, 0, 10, 0, 0, 0);
    cyc(1, 0, 200, 0, 0);  chk("R4 y only", int'(src), 8'h48);
    cyc(1, 0, 0, -300, 0); chk("R4 z only", int'(src), 8'h60);

    // R5
    tag = "R5";
    cfg(3'b000, 3'b111, 1, 10, 0, 0, 0);
    cyc(1, 5, -80, 70, 0); chk("R5 free fall", int'(src), 8'h55);
    cyc(1, 100, 0, 0, 0);  chk("R5 one axis high", int'(src), 8'h14);
    cfg(3'b000, 3'b000, 1, 10, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);    chk("R5 none enabled", int'(src), 8'h00);

    // R6
    tag = "R6";
    cfg(3'b001, 3'b000, 0, 10, 3, 0, 0);
    cyc(1, 100, 0, 0, 0); chk("R6 first", int'(src), 8'h02);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 100, 0, 0, 0); chk("R6 second", int'(src), 8'h02);
    cyc(1, 0, 0, 0, 0);   chk("R6 break", int'(src), 8'h00);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 100, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      chk("R6 before window", int'(src[6]), 0);
    end
    cyc(1, 100, 0, 0, 0); chk("R6 fourth", int'(src), 8'h42);

    // R7
    tag = "R7";
    cfg(3'b001, 3'b000, 0, 10, 0, 0, 0);
    cyc(1, 100, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);   chk("R7 read ignored", int'(src), 8'h42);
    cyc(1, 0, 0, 0, 0);   chk("R7 drops", int'(src), 8'h00);

    // R8
    tag = "R8";
    cfg(3'b001, 3'b000, 0, 10, 0, 1, 0);
    cyc(1, 100, 0, 0, 0); chk("R8 set", int'(src), 8'h42);
    cyc(1, 0, 0, 0, 0);   chk("R8 held", int'(src), 8'h42);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);   chk("R8 read clear", int'(src), 8'h00);
    cyc(1, 0, 0, 0, 0);   chk("R8 stays clear", int'(src), 8'h00);

    // R9
    tag = "R9";
    cyc(1, 100, 0, 0, 0);
    cyc(1, 100, 0, 0, 1); chk("R9 relatch", int'(src), 8'h42);
    cyc(1, 0, 0, 0, 1);   chk("R9 clear by sample", int'(src), 8'h00);

    // R10
    tag = "R10";
    cfg(3'b001, 3'b000, 0, 10, 0, 0, 1);
    cyc(1, 0, 0, 0, 0);   chk("R10 idle high", int'(irq), 1);
    cyc(1, 100, 0, 0, 0); chk("R10 active low", int'(irq), 0);

    // R11
    tag = "R11";
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);
    chk("R11 hold", int'(src), 8'h42);

    // random
    tag = "R2 R4 R5 R6 R7 R8 R9 random";
    for (int i = 0; i < 6000; i++) begin
      if (i % 40 == 0)
        cfg(3'(rnd()), 3'(rnd()), 1'(rnd()), rnd() % 128, rnd() % 4, 1'(rnd()), 1'(rnd()));
      cyc((rnd() % 4) != 0, (rnd() % 2400) - 1200, (rnd() % 600) - 300,
          ((rnd() % 8) == 0) ? -2048 : (rnd() % 4096) - 2048, (rnd() % 6) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule